// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two N-digit redundant binary operands and returns an (N+1)-digit redundant result. Every digit holds -1, 0 or +1 and travels on two wires, one flagging a positive digit and one flagging a negative digit. The word is built from identical digit slices. Each slice looks at its own operand digits and at three wires coming up from the slice just below it, so no signal crosses more than two slice boundaries. The delay through the adder is therefore the same at 4 digits as at 64.

Inside a slice the pair sum (range -2..+2) is split into an outgoing transfer and an interim digit. For a pair sum of +1 or -1, the split depends on whether the slice below holds any negative operand digit. This choice guarantees that the interim digit and the incoming transfer never share a nonzero sign. The final digit is then a zero/non-zero flag, formed as an XOR of three bits, and a polarity bit that steers the flag to the plus or the minus wire.

A parameter selects a purely combinational result or a result held in an output register with synchronous reset. Converting the result to two's complement is left to the consumer.

Top module: `sd_adder`

## Requirements
- R1: Digit pairs are encoded as (plus, minus): (1,0) means +1, (0,0) means 0 and (0,1) means -1. Operands never carry (1,1), and no result digit is ever (1,1).
- R2: The value of the result, sum over i of digit_i times 2^i, equals the value of x plus the value of y for every legal operand pair.
- R3: The result has N+1 digits, and digit N is the transfer out of the top slice. When every operand digit is +1, the result value is 2^(N+1)-2 and digit N is +1. When every operand digit is -1, the value is -(2^(N+1)-2) and digit N is -1.
- R4: Changing operand digit j, in either operand, can alter only result digits j, j+1 and j+2. At every slice, the interim digit and the incoming transfer are never both +1 and never both -1.
- R5: The lowest slice sees a zero transfer and a non-negative lower neighbour. As a result, digit 0 is -1 when x0+y0 is odd and 0 when it is even.
- R6: With REG_OUT=0, the result follows the operands in the same cycle, with no clock edge in between.
- R7: With REG_OUT=1, the result of an operand pair appears at the first rising clock edge after the pair is applied. Before that edge the previous result is held.
- R8: With REG_OUT=1, a synchronous active-high reset clears every result digit to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| x_p | input | N | Positive flags of operand x digits |
| x_n | input | N | Negative flags of operand x digits |
| y_p | input | N | Positive flags of operand y digits |
| y_n | input | N | Negative flags of operand y digits |
| s_p | output | N+1 | Positive flags of result digits |
| s_n | output | N+1 | Negative flags of result digits |

## Verification
Every property assumes that no operand digit arrives as the unused (1,1) pair; the slice logic gives that code no meaning. The stimulus only draws each digit from the three legal codes. It enumerates all 3^8 operand combinations on a 4-digit combinational instance and draws random legal digits for registered 32- and 64-digit instances. Directed all-plus, all-minus, single-digit perturbation and mid-run reset cases are added to these.

// File: rtl/sd_adder.sv
module sd_adder #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] x_p,
  input  logic [N-1:0] x_n,
  input  logic [N-1:0] y_p,
  input  logic [N-1:0] y_n,
  output logic [N:0]   s_p,
  output logic [N:0]   s_n
);
  localparam int VW = N + 3;

  function automatic logic signed [VW-1:0] sdval(input logic [N:0] p, input logic [N:0] n);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int i = 0; i <= N; i++) begin
      if (p[i]) acc = acc + ({{(VW-1){1'b0}}, 1'b1} << i);
      if (n[i]) acc = acc - ({{(VW-1){1'b0}}, 1'b1} << i);
    end
    return acc;
  endfunction

  // xfer_p/xfer_n[i]: transfer into position i; nneg[i]: lower pair holds no -1
  logic [N:0]   xfer_p, xfer_n, nneg;
  logic [N-1:0] wp, wn, d, b;
  logic [N:0]   rp, rn;

  assign xfer_p[0] = 1'b0;
  assign xfer_n[0] = 1'b0;
  assign nneg[0]   = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic xz, yz, odd;
    assign xz  = x_p[i] | x_n[i];
    assign yz  = y_p[i] | y_n[i];
    assign odd = xz ^ yz;

    assign nneg[i+1]   = ~(x_n[i] | y_n[i]);
    assign xfer_p[i+1] = (x_p[i] & y_p[i]) | (odd & (x_p[i] | y_p[i]) & nneg[i]);
    assign xfer_n[i+1] = (x_n[i] & y_n[i]) | (odd & (x_n[i] | y_n[i]) & ~nneg[i]);
    assign wn[i] = odd & nneg[i];
    assign wp[i] = odd & ~nneg[i];

    assign d[i]  = xz ^ yz ^ (xfer_p[i] | xfer_n[i]);
    assign b[i]  = (odd & nneg[i]) | (~odd & xfer_n[i]);
    assign rp[i] = d[i] & ~b[i];
    assign rn[i] = d[i] & b[i];

    assert_no_refold_R4: assert property (@(posedge clk) disable iff (rst)
      !((wp[i] && xfer_p[i]) || (wn[i] && xfer_n[i])))
      else $error("interim digit and transfer share a sign at %0d", i);
  end

  assign rp[N] = xfer_p[N];
  assign rn[N] = xfer_n[N];

  assert_legal_in_R1: assert property (@(posedge clk) disable iff (rst)
    ((x_p & x_n) == '0) && ((y_p & y_n) == '0))
    else $error("illegal operand digit code");

  assert_legal_out_R1: assert property (@(posedge clk) disable iff (rst)
    (s_p & s_n) == '0)
    else $error("illegal result digit code");

  if (REG_OUT) begin : g_reg
    logic [N:0] qp, qn;
    logic       rst_d;
    always_ff @(posedge clk) begin
      if (rst) begin
        qp <= '0;
        qn <= '0;
      end else begin
        qp <= rp;
        qn <= rn;
      end
      rst_d <= rst;
    end
    assign s_p = qp;
    assign s_n = qn;

    always @(posedge clk)
      if (rst_d)
        assert_reset_clear_R8: assert (s_p == '0 && s_n == '0)
          else $error("result not cleared by reset");

    assert_sum_value_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> sdval(s_p, s_n) ==
        $past(sdval({1'b0, x_p}, {1'b0, x_n}) + sdval({1'b0, y_p}, {1'b0, y_n})))
      else $error("registered sum value wrong");

    assert_low_digit_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> {s_p[0], s_n[0]} ==
        ($past((x_p[0] | x_n[0]) ^ (y_p[0] | y_n[0])) ? 2'b01 : 2'b00))
      else $error("lowest digit wrong");
  end else begin : g_comb
    assign s_p = rp;
    assign s_n = rn;

    assert_sum_value_R2: assert property (@(posedge clk) disable iff (rst)
      sdval(s_p, s_n) == sdval({1'b0, x_p}, {1'b0, x_n}) + sdval({1'b0, y_p}, {1'b0, y_n}))
      else $error("sum value wrong");

    assert_low_digit_R5: assert property (@(posedge clk) disable iff (rst)
      {s_p[0], s_n[0]} == (((x_p[0] | x_n[0]) ^ (y_p[0] | y_n[0])) ? 2'b01 : 2'b00))
      else $error("lowest digit wrong");
  end
endmodule

// File: tb/sd_adder_bench.sv
`timescale 1ns/1ps
module sd_adder_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst;

  logic [3:0]  a_xp, a_xn, a_yp, a_yn;  logic [4:0]  a_sp, a_sn;
  logic [31:0] b_xp, b_xn, b_yp, b_yn;  logic [32:0] b_sp, b_sn;
  logic [63:0] c_xp, c_xn, c_yp, c_yn;  logic [64:0] c_sp, c_sn;

  logic [3:0]  na_xp, na_xn, na_yp, na_yn;
  logic [31:0] nb_xp, nb_xn, nb_yp, nb_yn;
  logic [63:0] nc_xp, nc_xn, nc_yp, nc_yn;

  logic signed [67:0] eb_prev, ec_prev;
  int total = 0, bad = 0;
  bit done = 1'b0;

  sd_adder #(.N(4),  .REG_OUT(1'b0)) u_sd_adder_w4 (.clk(clk), .rst(rst),
    .x_p(a_xp), .x_n(a_xn), .y_p(a_yp), .y_n(a_yn), .s_p(a_sp), .s_n(a_sn));
  sd_adder #(.N(32), .REG_OUT(1'b1)) u_sd_adder_w32 (.clk(clk), .rst(rst),
    .x_p(b_xp), .x_n(b_xn), .y_p(b_yp), .y_n(b_yn), .s_p(b_sp), .s_n(b_sn));
  sd_adder #(.N(64), .REG_OUT(1'b1)) u_sd_adder (.clk(clk), .rst(rst),
    .x_p(c_xp), .x_n(c_xn), .y_p(c_yp), .y_n(c_yn), .s_p(c_sp), .s_n(c_sn));

  function automatic logic signed [67:0] sdv(input logic [64:0] p, input logic [64:0] n);
    logic signed [67:0] acc;
    acc = '0;
    for (int i = 0; i < 65; i++) begin
      if (p[i]) acc = acc + (68'sd1 <<< i);
      if (n[i]) acc = acc - (68'sd1 <<< i);
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic signed [67:0] act, input logic signed [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rnd(output logic [63:0] p, output logic [63:0] n);
    p = '0; n = '0;
    for (int i = 0; i < 64; i++) begin
      int unsigned v = $urandom % 3;
      if (v == 1) p[i] = 1'b1;
      else if (v == 2) n[i] = 1'b1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R2 w32 value", sdv(65'(b_sp), 65'(b_sn)), eb_prev);
    check("R2 w64 value", sdv(c_sp, c_sn), ec_prev);
    check("R1 w64 legal", 68'(c_sp & c_sn), 68'd0);
    check("R1 w32 legal", 68'(b_sp & b_sn), 68'd0);
    a_xp = na_xp; a_xn = na_xn; a_yp = na_yp; a_yn = na_yn;
    b_xp = nb_xp; b_xn = nb_xn; b_yp = nb_yp; b_yn = nb_yn;
    c_xp = nc_xp; c_xn = nc_xn; c_yp = nc_yp; c_yn = nc_yn;
    #1;
    check("R6 w4 same-cycle value", sdv(65'(a_sp), 65'(a_sn)),
          sdv(65'(a_xp), 65'(a_xn)) + sdv(65'(a_yp), 65'(a_yn)));
    check("R1 w4 legal", 68'(a_sp & a_sn), 68'd0);
    check("R5 w4 digit0", 68'({a_sp[0], a_sn[0]}),
          (((a_xp[0] | a_xn[0]) ^ (a_yp[0] | a_yn[0])) ? 68'd1 : 68'd0));
    check("R7 w64 held before edge", sdv(c_sp, c_sn), ec_prev);
    eb_prev = sdv(65'(b_xp), 65'(b_xn)) + sdv(65'(b_yp), 65'(b_yn));
    ec_prev = sdv(65'(c_xp), 65'(c_xn)) + sdv(65'(c_yp), 65'(c_yn));
  endtask

  task automatic set_all(input logic [63:0] xp, input logic [63:0] xn,
                         input logic [63:0] yp, input logic [63:0] yn);
    na_xp = xp[3:0];  na_xn = xn[3:0];  na_yp = yp[3:0];  na_yn = yn[3:0];
    nb_xp = xp[31:0]; nb_xn = xn[31:0]; nb_yp = yp[31:0]; nb_yn = yn[31:0];
    nc_xp = xp;       nc_xn = xn;       nc_yp = yp;       nc_yn = yn;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [63:0] p1, n1, p2, n2;
    logic [64:0] keep_p, keep_n, mask;
    void'($urandom(32'd4242));
    rst = 1'b1;
    set_all('0, '0, '0, '0);
    a_xp = '0; a_xn = '0; a_yp = '0; a_yn = '0;
    b_xp = '0; b_xn = '0; b_yp = '0; b_yn = '0;
    c_xp = '0; c_xn = '0; c_yp = '0; c_yn = '0;
    eb_prev = '0; ec_prev = '0;
    repeat (3) @(negedge clk);
    check("R8 w32 reset state", 68'({b_sp, b_sn}), 68'd0);
    check("R8 w64 reset state", sdv(c_sp, c_sn), 68'd0);
    check("R8 w64 reset plus wires", 68'(c_sp), 68'd0);
    rst = 1'b0;

    // R3 extremes: all +1 and all -1
    set_all('1, '0, '1, '0);
    step();
    check("R3 w4 top digit +1", 68'({a_sp[4], a_sn[4]}), 68'd2);
    check("R3 w4 max value", sdv(65'(a_sp), 65'(a_sn)), 68'sd30);
    @(posedge clk); #1;
    check("R3 w32 top digit +1", 68'({b_sp[32], b_sn[32]}), 68'd2);
    check("R3 w64 top digit +1", 68'({c_sp[64], c_sn[64]}), 68'd2);
    check("R3 w64 max value", sdv(c_sp, c_sn), (68'sd1 <<< 65) - 68'sd2);
    set_all('0, '1, '0, '1);
    step();
    check("R3 w4 top digit -1", 68'({a_sp[4], a_sn[4]}), 68'd1);
    check("R3 w4 min value", sdv(65'(a_sp), 65'(a_sn)), -68'sd30);
    @(posedge clk); #1;
    check("R3 w64 top digit -1", 68'({c_sp[64], c_sn[64]}), 68'd1);
    check("R3 w64 min value", sdv(c_sp, c_sn), 68'sd2 - (68'sd1 <<< 65));
    set_all(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
            64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555);
    step();

    // R2 exhaustive on 4 digits, random on 32 and 64 digits
    for (int k = 0; k < 6561; k++) begin
      int r = k;
      logic [3:0] xp, xn, yp, yn;
      xp = '0; xn = '0; yp = '0; yn = '0;
      for (int i = 0; i < 8; i++) begin
        int v = r % 3;
        r = r / 3;
        if (i < 4) begin
          if (v == 1) xp[i] = 1'b1; else if (v == 2) xn[i] = 1'b1;
        end else begin
          if (v == 1) yp[i-4] = 1'b1; else if (v == 2) yn[i-4] = 1'b1;
        end
      end
      rnd(p1, n1); rnd(p2, n2);
      set_all(p1, n1, p2, n2);
      na_xp = xp; na_xn = xn; na_yp = yp; na_yn = yn;
      step();
    end

    // R4 locality: perturb one digit position, only three result digits may move
    for (int t = 0; t < 16; t++) begin
      int j = int'($urandom % 62);
      rnd(p1, n1); rnd(p2, n2);
      set_all(p1, n1, p2, n2);
      step();
      @(posedge clk); #1;
      keep_p = c_sp; keep_n = c_sn;
      p1[j] = ~p1[j] & ~n1[j];
      n1[j] = 1'b0;
      n2[j] = ~n2[j] & ~p2[j];
      p2[j] = 1'b0;
      set_all(p1, n1, p2, n2);
      step();
      @(posedge clk); #1;
      mask = ~(65'b111 << j);
      check("R4 locality plus wires", 68'((c_sp ^ keep_p) & mask), 68'd0);
      check("R4 locality minus wires", 68'((c_sn ^ keep_n) & mask), 68'd0);
    end

    // R8 mid-run synchronous reset
    set_all('1, '0, '1, '0);
    step();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 w32 mid-run clear", 68'({b_sp, b_sn}), 68'd0);
    check("R8 w64 mid-run clear", 68'({c_sp, c_sn}), 68'd0);
    @(negedge clk);
    rst = 1'b0;
    step();
    step();
    finish_up();
  end
endmodule